// File: doc/BRIEF.md
# Buffer Range Internet Checksum Engine

This block walks an inclusive range of addresses in an on-chip packet buffer and produces the 16-bit ones' complement checksum used by IP, TCP and UDP headers. It fetches one byte per clock through a synchronous read port and pairs the bytes into big-endian words. It folds every carry back into the sum, and the register holds the complemented total. The range may run through the end of a circular receive region, in which case the read address jumps back to the region's lower bound.

Software supplies the first and last byte addresses and the bounds of the circular region. It then pulses a start request with the checksum-mode enable set. The engine reports busy while it works. On completion it drops busy, raises a sticky done flag and, if both interrupt enables are on, drives its interrupt line. The result is read as a high byte and a low byte. A new accepted start clears the done flag, and software may also clear it with a clear pulse.

Top module: `csum_engine`

## Requirements
- R1: Bytes are paired in fetch order, and the first byte of each pair is the high byte of the 16-bit word (bytes 12h,34h give the word 1234h).
- R2: When the range holds an odd count of bytes, the last byte is summed as the high byte of a word whose low byte is 00h.
- R3: Words are added with end-around carry, and the result is the bitwise complement of the sum. Bytes 89h,ABh,CDh give A953h, and ten bytes of FFh give 0000h.
- R4: Both the first and the last programmed address are read and summed. Between them, addresses rise by one per fetch.
- R5: The engine fetches exactly one byte per clock. For an N-byte range, done is first high N+1 clock edges after the edge that accepted the start.
- R6: Busy rises on the edge that accepts a start and falls on the same edge that sets done. While busy is high, done reads 0.
- R7: The interrupt output is high only when done, the DMA interrupt enable and the global interrupt enable are all 1.
- R8: A fetch at the region's upper bound is followed by a fetch at the region's lower bound.
- R9: A start request while busy is ignored. The running operation keeps its range, its latency and its result.
- R10: A start request with the checksum-mode enable at 0 is ignored, and busy and the read strobe stay 0.
- R11: A done-clear pulse sets done to 0. When completion and a clear fall on the same edge, completion wins and done reads 1.
- R12: The result is presented as csum_hi (bits 15:8) and csum_lo (bits 7:0), and both read 00h after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_first | input | 13 | Address of the first byte in the range |
| cfg_last | input | 13 | Address of the last byte in the range |
| ring_lo | input | 13 | Lower bound of the circular receive region |
| ring_hi | input | 13 | Upper bound of the circular receive region |
| start_req | input | 1 | Start request pulse |
| csum_en | input | 1 | Checksum-mode enable sampled with start_req |
| done_clr | input | 1 | Clears the done flag |
| ie_dma | input | 1 | Completion interrupt enable |
| ie_glob | input | 1 | Global interrupt enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| csum_hi | output | 8 | Result bits 15:8 |
| csum_lo | output | 8 | Result bits 7:0 |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | 13 | Buffer read address |
| rd_data | input | 8 | Buffer read data, one cycle after rd_en |

## Verification
Completion of an operation and a software clear of the done flag can land on the same clock edge. The bench holds done_clr high for a whole short operation. At the edge where the last byte is summed it expects done to read 1, and on the following edge it expects 0. A second collision, a start request that arrives while busy, is placed mid-run with a different range. It is judged by requiring the original latency and the original checksum.

// File: rtl/csum_pkg.sv
// Shared constants, the read-tag type and the ones' complement adder.
// Assumes byte-wide buffer data and a 16-bit checksum word.
package csum_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;

    // Tag that travels alongside a read through the RAM latency.
    typedef struct packed {
        logic vld;
        logic last;
    } rd_tag_t;

    // Adds two words and folds the carry out of the top bit back into bit 0.
    function automatic logic [WORD_W-1:0] oc_add(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
        logic [WORD_W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, t[WORD_W]};
    endfunction
endpackage

// File: rtl/csum_ctrl.sv
// Operation control: accepts a start, holds busy and owns the done flag.
// Assumes last_summed pulses exactly once per operation, while busy.
module csum_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic csum_en,
    input  logic done_clr,
    input  logic last_summed,
    output logic go,
    output logic busy,
    output logic done
);
    logic busy_q;
    logic done_q;

    // A start is taken only when idle and in checksum mode.
    assign go = start_req & csum_en & ~busy_q;

    // Busy covers both the fetch phase and the one-cycle drain.
    always_ff @(posedge clk) begin
        if (!rst_n)           busy_q <= 1'b0;
        else if (go)          busy_q <= 1'b1;
        else if (last_summed) busy_q <= 1'b0;
    end

    // Done: completion beats a software clear; a new start clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)           done_q <= 1'b0;
        else if (last_summed) done_q <= 1'b1;
        else if (go)          done_q <= 1'b0;
        else if (done_clr)    done_q <= 1'b0;
    end

    assign busy = busy_q;
    assign done = done_q;

    // R6
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !last_summed |=> busy_q);
endmodule

// File: rtl/csum_addr_gen.sv
// Read address sequencer: walks first..last, wrapping at the ring upper bound.
// Assumes go only arrives while no walk is in progress.
module csum_addr_gen #(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] cfg_first,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic [ADDR_W-1:0] ring_lo,
    input  logic [ADDR_W-1:0] ring_hi,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_last
);
    logic              issuing_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] rlo_q;
    logic [ADDR_W-1:0] rhi_q;
    logic [ADDR_W-1:0] addr_nxt;

    // Next address, with the jump from the ring top to the ring bottom.
    always_comb begin
        if (addr_q == rhi_q) addr_nxt = rlo_q;
        else                 addr_nxt = addr_q + 1'b1;
    end

    // Latch the range at start, then advance one address per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing_q <= 1'b0;
            addr_q    <= '0;
            last_q    <= '0;
            rlo_q     <= '0;
            rhi_q     <= '0;
        end else if (go) begin
            issuing_q <= 1'b1;
            addr_q    <= cfg_first;
            last_q    <= cfg_last;
            rlo_q     <= ring_lo;
            rhi_q     <= ring_hi;
        end else if (issuing_q) begin
            if (addr_q == last_q) issuing_q <= 1'b0;
            else                  addr_q    <= addr_nxt;
        end
    end

    assign rd_en   = issuing_q;
    assign rd_addr = addr_q;
    assign rd_last = issuing_q & (addr_q == last_q);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_last && (rd_addr != rhi_q)
        |=> rd_en && (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    // R8
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_last && (rd_addr == rhi_q) |=> rd_en && (rd_addr == rlo_q));
endmodule

// File: rtl/csum_accum.sv
// Accumulator: pairs returned bytes big-endian and keeps the folded sum.
// Assumes read data arrives exactly one clock after the tagged read.
module csum_accum
    import csum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  rd_tag_t           issue_tag,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              last_summed,
    output logic [WORD_W-1:0] result
);
    rd_tag_t           tag_q;
    logic              phase_q;
    logic [BYTE_W-1:0] hi_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] res_q;
    logic [WORD_W-1:0] word;
    logic              add_now;
    logic [WORD_W-1:0] acc_nxt;

    // Form the word: a held high byte with this byte, or this byte padded.
    always_comb begin
        if (phase_q) word = {hi_q, rd_data};
        else         word = {rd_data, {BYTE_W{1'b0}}};
        add_now = tag_q.vld & (phase_q | tag_q.last);
        acc_nxt = oc_add(acc_q, word);
    end

    // Delay the read tag by the RAM latency.
    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= issue_tag;
    end

    // Pair bytes and accumulate; clear on every new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            hi_q    <= '0;
            acc_q   <= '0;
        end else if (go) begin
            phase_q <= 1'b0;
            acc_q   <= '0;
        end else if (tag_q.vld) begin
            if (add_now) begin
                acc_q   <= acc_nxt;
                phase_q <= 1'b0;
            end else begin
                hi_q    <= rd_data;
                phase_q <= 1'b1;
            end
        end
    end

    // Capture the complemented sum when the final byte is folded in.
    always_ff @(posedge clk) begin
        if (!rst_n)                      res_q <= '0;
        else if (tag_q.vld && tag_q.last) res_q <= ~acc_nxt;
    end

    assign last_summed = tag_q.vld & tag_q.last;
    assign result      = res_q;

    // R5
    one_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_tag.vld |=> tag_q.vld);
endmodule

// File: rtl/csum_engine.sv
// Top: buffer-range Internet checksum engine with done/interrupt handshake.
// Assumes a synchronous byte-wide buffer RAM with one cycle of read latency.
module csum_engine
    import csum_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_first,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic [ADDR_W-1:0] ring_lo,
    input  logic [ADDR_W-1:0] ring_hi,
    input  logic              start_req,
    input  logic              csum_en,
    input  logic              done_clr,
    input  logic              ie_dma,
    input  logic              ie_glob,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic [BYTE_W-1:0] csum_hi,
    output logic [BYTE_W-1:0] csum_lo,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    logic              go;
    logic              last_summed;
    logic              rd_last;
    rd_tag_t           issue_tag;
    logic [WORD_W-1:0] result;

    csum_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .csum_en     (csum_en),
        .done_clr    (done_clr),
        .last_summed (last_summed),
        .go          (go),
        .busy        (busy),
        .done        (done)
    );

    csum_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .cfg_first (cfg_first),
        .cfg_last  (cfg_last),
        .ring_lo   (ring_lo),
        .ring_hi   (ring_hi),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_last   (rd_last)
    );

    // Tag each read with its validity and whether it is the final byte.
    always_comb begin
        issue_tag.vld  = rd_en;
        issue_tag.last = rd_last;
    end

    csum_accum u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .issue_tag   (issue_tag),
        .rd_data     (rd_data),
        .last_summed (last_summed),
        .result      (result)
    );

    assign irq     = done & ie_dma & ie_glob;
    assign csum_hi = result[WORD_W-1:BYTE_W];
    assign csum_lo = result[BYTE_W-1:0];

    // R6
    busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R10
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);
endmodule

// File: tb/csum_engine_tb_top.sv
module csum_engine_tb_top;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] cfg_first, cfg_last, ring_lo, ring_hi;
    logic          start_req, csum_en, done_clr, ie_dma, ie_glob;
    logic          busy, done, irq, rd_en;
    logic [7:0]    csum_hi, csum_lo, rd_data;
    logic [AW-1:0] rd_addr;
    logic [7:0]    mem [0:255];
    int            n_chk = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    csum_engine dut_i (.*);

    always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                           input logic [AW-1:0] hi);
        return (a == hi) ? lo : AW'(a + 1);
    endfunction

    // Expected checksum: wide sum of big-endian pairs, then fold and invert.
    function automatic logic [15:0] model(input logic [AW-1:0] f, input logic [AW-1:0] l,
                                          input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                                          output int n);
        logic [31:0]   acc = 0;
        logic [AW-1:0] a = f;
        logic [7:0]    hb = 0;
        n = 0;
        for (int i = 0; i < 4000; i++) begin
            if (n % 2 == 0) hb = mem[a[7:0]];
            else acc += {16'h0, hb, mem[a[7:0]]};
            n++;
            if (a == l) break;
            a = step(a, lo, hi);
        end
        if (n % 2 == 1) acc += {16'h0, hb, 8'h00};
        while (acc[31:16] != 0) acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        return ~acc[15:0];
    endfunction

    task automatic launch(input logic [AW-1:0] f, input logic [AW-1:0] l,
                          input logic [AW-1:0] lo, input logic [AW-1:0] hi);
        @(negedge clk);
        cfg_first = f; cfg_last = l; ring_lo = lo; ring_hi = hi;
        start_req = 1'b1; csum_en = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int          n, cyc;
        logic [15:0] exp;
        for (int i = 0; i < 256; i++) mem[i] = 8'(((i * 73) + 29) ^ (i >> 3));
        mem[100] = 8'h89; mem[101] = 8'hAB; mem[102] = 8'hCD;
        mem[110] = 8'h12; mem[111] = 8'h34;
        for (int i = 200; i < 210; i++) mem[i] = 8'hFF;
        rst_n = 1'b0; start_req = 0; csum_en = 0; done_clr = 0; ie_dma = 0; ie_glob = 0;
        cfg_first = 0; cfg_last = 0; ring_lo = 0; ring_hi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset busy/done/irq/rd_en", {busy, done, irq, rd_en}, 4'b0000);
        chk("R12 reset result", {csum_hi, csum_lo}, 16'h0000);

        // R3 R2 worked example, and R12 byte split
        launch(100, 102, 8, 47); wait_done(cyc);
        chk("R3 odd example", {csum_hi, csum_lo}, 16'hA953);
        chk("R12 hi byte", csum_hi, 8'hA9);
        chk("R12 lo byte", csum_lo, 8'h53);
        chk("R5 latency 3 bytes", cyc, 4);
        // R1 big-endian pairing
        launch(110, 111, 8, 47); wait_done(cyc);
        chk("R1 pair order", {csum_hi, csum_lo}, 16'hEDCB);
        // R3 all-ones carry folding
        launch(200, 209, 8, 47); wait_done(cyc);
        chk("R3 all FF", {csum_hi, csum_lo}, 16'h0000);
        // R4 single byte range
        launch(5, 5, 8, 47); wait_done(cyc);
        exp = model(5, 5, 8, 47, n);
        chk("R4 single byte", {csum_hi, csum_lo}, exp);
        chk("R2 single byte padded", {csum_hi, csum_lo}, {~mem[5], 8'hFF});

        // R7 interrupt gating
        for (int m = 0; m < 4; m++) begin
            @(negedge clk); ie_dma = m[0]; ie_glob = m[1];
            #1 chk("R7 irq gating", irq, (m == 3));
        end
        ie_dma = 0; ie_glob = 0;

        // R10 start without checksum mode
        @(negedge clk); start_req = 1; csum_en = 0;
        @(negedge clk); start_req = 0;
        chk("R10 not started", {busy, rd_en, done}, 3'b001);

        // R11 clear by software
        @(negedge clk); done_clr = 1;
        @(negedge clk); done_clr = 0;
        chk("R11 clear", done, 0);

        // R11 completion and clear on the same edge
        done_clr = 1;
        launch(20, 22, 8, 47); wait_done(cyc);
        chk("R11 completion wins", done, 1);
        @(negedge clk);
        chk("R11 clear afterwards", done, 0);
        done_clr = 0;

        // R9 start while busy is ignored
        launch(60, 71, 8, 47);
        repeat (4) @(negedge clk);
        cfg_first = 0; cfg_last = 0; start_req = 1;
        @(negedge clk); start_req = 0;
        cyc = 5;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        exp = model(60, 71, 8, 47, n);
        chk("R9 result kept", {csum_hi, csum_lo}, exp);
        chk("R9 latency kept", cyc, 13);

        // R8 wrap through the ring bound
        launch(45, 10, 8, 47); wait_done(cyc);
        exp = model(45, 10, 8, 47, n);
        chk("R8 wrap result", {csum_hi, csum_lo}, exp);
        chk("R8 wrap latency", cyc, n + 1);

        // Sweep: R1 R2 R3 R4 R5 R6 R8 over start positions and lengths
        for (int s = 32; s < 48; s++) begin
            for (int len = 1; len <= 24; len++) begin
                logic [AW-1:0] l;
                l = AW'(s);
                for (int k = 1; k < len; k++) l = step(l, 8, 47);
                launch(AW'(s), l, 8, 47);
                chk("R6 busy while running", {busy, done}, 2'b10);
                wait_done(cyc);
                exp = model(AW'(s), l, 8, 47, n);
                chk("R3 sweep result", {csum_hi, csum_lo}, exp);
                chk("R5 sweep latency", cyc, len + 1);
                chk("R6 busy dropped", busy, 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule